// File: doc/BRIEF.md
# Serial Port Register Front End with Interrupt Status

This block is the register window of a serial port. A host reaches it through a simple single-cycle bus: valid, write, 12-bit byte address and 32-bit data. The block holds the configuration registers (baud divisors, low-power divisor, line control, control, FIFO level select and DMA control) and presents them on output pins. It also forwards transmit characters on a strobe, pops the receive FIFO on a data read, and reports the FIFO flags it is given. Serial framing and the FIFOs themselves live outside the block.

The block also runs the interrupt logic. A raw status vector is set by events: a transmit write sets one bit, and a pulse from the receive FIFO sets another. A write-one-to-clear register removes status bits. A mask register selects which status bits reach the single level-sensitive interrupt pin. Eight identification bytes are decoded at the top of the 4 KB window.

Top module: `serial_csr_top`

## Requirements
- R1: After reset the control register reads 0x300, the FIFO level select register reads 0x12, and every other stored register, the raw status, the mask and the interrupt pin are zero.
- R2: Registers are selected by word index (byte address bits 11:2). Indices 8 (low-power divisor), 9 (integer baud), 10 (fractional baud), 11 (line control), 12 (control), 13 (level select) and 18 (DMA control) store bits 15:0 of a write. Each reads back zero-extended and drives its output pin from the next cycle.
- R3: Index 1 always reads zero. A write to index 1 updates the control register, which is then visible at index 12.
- R4: Index 6 reads the flags: bit 7 TX empty, bit 6 RX full, bit 5 TX full, bit 4 RX empty, all other bits zero. Writes to index 6 change nothing.
- R5: Byte addresses 0xFE0, 0xFE4, through 0xFFC read the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that address order.
- R6: A write to index 0 raises tx_strobe for exactly the next cycle, with tx_data equal to bits 7:0 of the write. The same write sets raw status bit 5.
- R7: A cycle with rx_event high sets raw status bit 4.
- R8: Index 14 is the mask and stores bits 10:0 of a write. Index 15 reads the raw status. Index 16 reads the raw status AND the mask. The irq pin is high exactly when that AND is nonzero.
- R9: A write to index 17 clears every raw status bit whose write-data bit is 1 and leaves the others. A bit that is set by an event in the same cycle stays set.
- R10: A read of index 0 returns rx_data zero-extended and raises rx_pop in that same cycle. No other access raises rx_pop.
- R11: Unmapped addresses read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational in the request cycle |
| rx_data_i | input | 12 | Head entry of the receive FIFO |
| rx_event_i | input | 1 | Receive FIFO interrupt event pulse |
| rx_empty_i | input | 1 | Receive FIFO empty flag |
| rx_full_i | input | 1 | Receive FIFO full flag |
| tx_empty_i | input | 1 | Transmit path empty flag |
| tx_full_i | input | 1 | Transmit path full flag |
| rx_pop_o | output | 1 | Pop strobe to the receive FIFO |
| tx_strobe_o | output | 1 | Transmit character valid |
| tx_data_o | output | 8 | Transmit character |
| lpdiv_o | output | 16 | Low-power divisor |
| ibaud_o | output | 16 | Integer baud divisor |
| fbaud_o | output | 16 | Fractional baud divisor |
| line_o | output | 16 | Line control |
| ctrl_o | output | 16 | Control |
| level_o | output | 16 | FIFO level select |
| dma_o | output | 16 | DMA control |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a bus access lasts exactly one cycle, and that rx_event is a clean synchronous pulse with no unknown values while reset is released. They also treat a data-register write and a clear write as mutually exclusive, because the bus carries only one access per cycle. The stimulus drives every input on the falling edge, so one access occupies exactly one rising edge. The only overlap it produces is the legal one: a clear write combined with an rx_event pulse in the same cycle, used to exercise the set-wins rule.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

    localparam int IDX_W = 10;

    localparam logic [IDX_W-1:0] IX_DATA  = 10'd0;
    localparam logic [IDX_W-1:0] IX_CALIAS = 10'd1;
    localparam logic [IDX_W-1:0] IX_FLAG  = 10'd6;
    localparam logic [IDX_W-1:0] IX_LPDIV = 10'd8;
    localparam logic [IDX_W-1:0] IX_IBAUD = 10'd9;
    localparam logic [IDX_W-1:0] IX_FBAUD = 10'd10;
    localparam logic [IDX_W-1:0] IX_LINE  = 10'd11;
    localparam logic [IDX_W-1:0] IX_CTRL  = 10'd12;
    localparam logic [IDX_W-1:0] IX_LEVEL = 10'd13;
    localparam logic [IDX_W-1:0] IX_MASK  = 10'd14;
    localparam logic [IDX_W-1:0] IX_RAW   = 10'd15;
    localparam logic [IDX_W-1:0] IX_MIS   = 10'd16;
    localparam logic [IDX_W-1:0] IX_CLR   = 10'd17;
    localparam logic [IDX_W-1:0] IX_DMA   = 10'd18;

    localparam int TX_BIT = 5;
    localparam int RX_BIT = 4;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_CALIAS, SEL_FLAG, SEL_LPDIV, SEL_IBAUD,
        SEL_FBAUD, SEL_LINE, SEL_CTRL, SEL_LEVEL, SEL_MASK, SEL_RAW,
        SEL_MIS, SEL_CLR, SEL_DMA, SEL_ID
    } sel_e;

endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
    import serial_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic [2:0]        id_idx_o
);
    localparam int HI_W = ADDR_W - 5;

    logic [IDX_W-1:0] idx;
    logic             unused_lsb;

    assign idx        = IDX_W'(addr_i[ADDR_W-1:2]);
    assign unused_lsb = ^addr_i[1:0];
    assign id_idx_o   = addr_i[4:2];

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i[ADDR_W-1:5] == {HI_W{1'b1}}) begin
            sel_o = SEL_ID;
        end else begin
            unique case (idx)
                IX_DATA:   sel_o = SEL_DATA;
                IX_CALIAS: sel_o = SEL_CALIAS;
                IX_FLAG:   sel_o = SEL_FLAG;
                IX_LPDIV:  sel_o = SEL_LPDIV;
                IX_IBAUD:  sel_o = SEL_IBAUD;
                IX_FBAUD:  sel_o = SEL_FBAUD;
                IX_LINE:   sel_o = SEL_LINE;
                IX_CTRL:   sel_o = SEL_CTRL;
                IX_LEVEL:  sel_o = SEL_LEVEL;
                IX_MASK:   sel_o = SEL_MASK;
                IX_RAW:    sel_o = SEL_RAW;
                IX_MIS:    sel_o = SEL_MIS;
                IX_CLR:    sel_o = SEL_CLR;
                IX_DMA:    sel_o = SEL_DMA;
                default:   sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/serial_csr_idrom.sv
module serial_csr_idrom (
    input  logic [2:0] idx_i,
    output logic [7:0] byte_o
);
    always_comb begin
        unique case (idx_i)
            3'd0:    byte_o = 8'h11;
            3'd1:    byte_o = 8'h10;
            3'd2:    byte_o = 8'h14;
            3'd3:    byte_o = 8'h00;
            3'd4:    byte_o = 8'h0D;
            3'd5:    byte_o = 8'hF0;
            3'd6:    byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/serial_csr_irq.sv
module serial_csr_irq #(
    parameter int IRQ_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we_i,
    input  logic [IRQ_W-1:0] mask_wdata_i,
    input  logic             clr_we_i,
    input  logic [IRQ_W-1:0] clr_bits_i,
    input  logic [IRQ_W-1:0] set_bits_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic [IRQ_W-1:0] masked_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        for (int b = 0; b < IRQ_W; b++) begin
            if (set_bits_i[b])                     st_d.raw[b] = 1'b1;
            else if (clr_we_i && clr_bits_i[b])    st_d.raw[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign mask_o   = st_q.mask;
    assign masked_o = st_q.raw & st_q.mask;
    assign irq_o    = |masked_o;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits_i != '0) |=> ((raw_o & $past(set_bits_i)) == $past(set_bits_i)));

    // R9
    clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((raw_o & $past(clr_bits_i & ~set_bits_i)) == '0));

    // R8
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw_o != '0) && (mask_o != '0)));
endmodule

// File: rtl/serial_csr_top.sv
module serial_csr_top
    import serial_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16,
    parameter int IRQ_W  = 11,
    parameter int RXD_W  = 12,
    parameter int TXD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [RXD_W-1:0]  rx_data_i,
    input  logic              rx_event_i,
    input  logic              rx_empty_i,
    input  logic              rx_full_i,
    input  logic              tx_empty_i,
    input  logic              tx_full_i,
    output logic              rx_pop_o,
    output logic              tx_strobe_o,
    output logic [TXD_W-1:0]  tx_data_o,
    output logic [CFG_W-1:0]  lpdiv_o,
    output logic [CFG_W-1:0]  ibaud_o,
    output logic [CFG_W-1:0]  fbaud_o,
    output logic [CFG_W-1:0]  line_o,
    output logic [CFG_W-1:0]  ctrl_o,
    output logic [CFG_W-1:0]  level_o,
    output logic [CFG_W-1:0]  dma_o,
    output logic              irq_o
);
    localparam logic [CFG_W-1:0] CTRL_RST  = CFG_W'(16'h0300);
    localparam logic [CFG_W-1:0] LEVEL_RST = CFG_W'(16'h0012);

    typedef struct packed {
        logic [CFG_W-1:0] lpdiv;
        logic [CFG_W-1:0] ibaud;
        logic [CFG_W-1:0] fbaud;
        logic [CFG_W-1:0] line;
        logic [CFG_W-1:0] ctrl;
        logic [CFG_W-1:0] level;
        logic [CFG_W-1:0] dma;
        logic [TXD_W-1:0] txd;
        logic             txs;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    sel_e             sel;
    logic [2:0]       id_idx;
    logic [7:0]       id_byte;
    logic             wr, rd;
    logic [IRQ_W-1:0] set_bits, raw, mask, masked;
    logic [CFG_W-1:0] wcfg;
    logic             unused_wdata;

    serial_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i   (bus_addr_i),
        .sel_o    (sel),
        .id_idx_o (id_idx)
    );

    serial_csr_idrom u_idrom (
        .idx_i  (id_idx),
        .byte_o (id_byte)
    );

    assign wr           = bus_valid_i &&  bus_write_i;
    assign rd           = bus_valid_i && !bus_write_i;
    assign wcfg         = bus_wdata_i[CFG_W-1:0];
    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        set_bits = '0;
        set_bits[TX_BIT] = wr && (sel == SEL_DATA);
        set_bits[RX_BIT] = rx_event_i;
    end

    serial_csr_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (wr && (sel == SEL_MASK)),
        .mask_wdata_i (bus_wdata_i[IRQ_W-1:0]),
        .clr_we_i     (wr && (sel == SEL_CLR)),
        .clr_bits_i   (bus_wdata_i[IRQ_W-1:0]),
        .set_bits_i   (set_bits),
        .raw_o        (raw),
        .mask_o       (mask),
        .masked_o     (masked),
        .irq_o        (irq_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.txs = 1'b0;
        if (wr) begin
            unique case (sel)
                SEL_DATA: begin
                    st_d.txs = 1'b1;
                    st_d.txd = bus_wdata_i[TXD_W-1:0];
                end
                SEL_CALIAS, SEL_CTRL: st_d.ctrl  = wcfg;
                SEL_LPDIV:            st_d.lpdiv = wcfg;
                SEL_IBAUD:            st_d.ibaud = wcfg;
                SEL_FBAUD:            st_d.fbaud = wcfg;
                SEL_LINE:             st_d.line  = wcfg;
                SEL_LEVEL:            st_d.level = wcfg;
                SEL_DMA:              st_d.dma   = wcfg;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ctrl  <= CTRL_RST;
            st_q.level <= LEVEL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            SEL_DATA:  bus_rdata_o = DATA_W'(rx_data_i);
            SEL_FLAG:  bus_rdata_o = DATA_W'({tx_empty_i, rx_full_i, tx_full_i, rx_empty_i, 4'b0000});
            SEL_LPDIV: bus_rdata_o = DATA_W'(st_q.lpdiv);
            SEL_IBAUD: bus_rdata_o = DATA_W'(st_q.ibaud);
            SEL_FBAUD: bus_rdata_o = DATA_W'(st_q.fbaud);
            SEL_LINE:  bus_rdata_o = DATA_W'(st_q.line);
            SEL_CTRL:  bus_rdata_o = DATA_W'(st_q.ctrl);
            SEL_LEVEL: bus_rdata_o = DATA_W'(st_q.level);
            SEL_MASK:  bus_rdata_o = DATA_W'(mask);
            SEL_RAW:   bus_rdata_o = DATA_W'(raw);
            SEL_MIS:   bus_rdata_o = DATA_W'(masked);
            SEL_DMA:   bus_rdata_o = DATA_W'(st_q.dma);
            SEL_ID:    bus_rdata_o = DATA_W'(id_byte);
            default:   bus_rdata_o = '0;
        endcase
    end

    assign rx_pop_o    = rd && (sel == SEL_DATA);
    assign tx_strobe_o = st_q.txs;
    assign tx_data_o   = st_q.txd;
    assign lpdiv_o     = st_q.lpdiv;
    assign ibaud_o     = st_q.ibaud;
    assign fbaud_o     = st_q.fbaud;
    assign line_o      = st_q.line;
    assign ctrl_o      = st_q.ctrl;
    assign level_o     = st_q.level;
    assign dma_o       = st_q.dma;

    // R6
    tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_DATA)) |=> (tx_strobe_o && (tx_data_o == $past(bus_wdata_i[TXD_W-1:0]))));

    // R6
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (sel == SEL_DATA)) |=> !tx_strobe_o);

    // R11
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_NONE)) |=> ($stable(ctrl_o) && $stable(line_o) && $stable(level_o) && $stable(dma_o)));

    // R10
    pop_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> (bus_valid_i && !bus_write_i));
endmodule

// File: tb/serial_csr_top_tb_top.sv
module serial_csr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [11:0] rx_data = '0;
    logic        rx_event = 1'b0, rx_empty = 1'b1, rx_full = 1'b0;
    logic        tx_empty = 1'b1, tx_full = 1'b0;
    logic        rx_pop, tx_strobe, irq;
    logic [7:0]  tx_data;
    logic [15:0] lpdiv, ibaud, fbaud, line, ctrl, level, dma;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_cfg [0:18];
    logic [10:0] m_mask, m_raw;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_csr_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .rx_data_i(rx_data), .rx_event_i(rx_event),
        .rx_empty_i(rx_empty), .rx_full_i(rx_full),
        .tx_empty_i(tx_empty), .tx_full_i(tx_full),
        .rx_pop_o(rx_pop), .tx_strobe_o(tx_strobe), .tx_data_o(tx_data),
        .lpdiv_o(lpdiv), .ibaud_o(ibaud), .fbaud_o(fbaud), .line_o(line),
        .ctrl_o(ctrl), .level_o(level), .dma_o(dma), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] id_byte(input int k);
        case (k)
            0: return 32'h11; 1: return 32'h10; 2: return 32'h14; 3: return 32'h00;
            4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return {20'd0, rx_data};
            6: return {24'd0, tx_empty, rx_full, tx_full, rx_empty, 4'd0};
            8, 9, 10, 11, 12, 13, 18: return m_cfg[idx] & 32'hFFFF;
            14: return {21'd0, m_mask};
            15: return {21'd0, m_raw};
            16: return {21'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [31:0] v);
        case (idx)
            0: m_raw[5] = 1'b1;
            1: m_cfg[12] = v;
            8, 9, 10, 11, 12, 13, 18: m_cfg[idx] = v;
            14: m_mask = v[10:0];
            17: m_raw = m_raw & ~v[10:0];
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] v, input logic ev);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v; rx_event = ev;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; rx_event = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] v, output logic pop);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata; pop = rx_pop;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        p;
        int          idx;
        int          cfg_idx [9] = '{1, 8, 9, 10, 11, 12, 13, 14, 18};
        void'($urandom(32'd1234));
        for (int i = 0; i < 19; i++) m_cfg[i] = 32'd0;
        m_cfg[12] = 32'h300; m_cfg[13] = 32'h12;
        m_mask = '0; m_raw = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 ctrl pin", {16'd0, ctrl}, 32'h300);
        check("R1 level pin", {16'd0, level}, 32'h12);
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int k = 8; k <= 18; k++) begin
            if (k == 17) continue;
            bus_rd(12'(k * 4), v, p);
            check("R1 reset read", v, exp_read(k));
        end

        // R5 identification bytes
        for (int k = 0; k < 8; k++) begin
            bus_rd(12'hFE0 + 12'(k * 4), v, p);
            check("R5 id byte", v, id_byte(k));
        end

        // R4 flags reflect inputs, writes ignored
        rx_empty = 1'b0; rx_full = 1'b1; tx_empty = 1'b0; tx_full = 1'b1;
        bus_rd(12'h018, v, p);
        check("R4 flags", v, 32'h60);
        bus_wr(12'h018, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h018, v, p);
        check("R4 flags after write", v, 32'h60);
        rx_empty = 1'b1; rx_full = 1'b0; tx_empty = 1'b1; tx_full = 1'b0;
        bus_rd(12'h018, v, p);
        check("R4 flags idle", v, 32'h90);

        // R3 alias
        bus_wr(12'h004, 32'h0000_ABCD, 1'b0); model_write(1, 32'h0000_ABCD);
        bus_rd(12'h004, v, p);
        check("R3 alias reads zero", v, 32'd0);
        bus_rd(12'h030, v, p);
        check("R3 alias updates ctrl", v, 32'hABCD);

        // R6 transmit write
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h1234_56A7;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R6 tx strobe", {31'd0, tx_strobe}, 32'd1);
        check("R6 tx data", {24'd0, tx_data}, 32'hA7);
        model_write(0, 32'h1234_56A7);
        @(negedge clk);
        check("R6 strobe one cycle", {31'd0, tx_strobe}, 32'd0);
        bus_rd(12'h03C, v, p);
        check("R6 raw tx bit", v, exp_read(15));

        // R10 data read pops
        rx_data = 12'h4C3;
        bus_rd(12'h000, v, p);
        check("R10 rx data", v, 32'h4C3);
        check("R10 pop on data read", {31'd0, p}, 32'd1);
        bus_rd(12'h030, v, p);
        check("R10 no pop elsewhere", {31'd0, p}, 32'd0);

        // R7 receive event
        @(negedge clk); rx_event = 1'b1; @(negedge clk); rx_event = 1'b0;
        m_raw[4] = 1'b1;
        bus_rd(12'h03C, v, p);
        check("R7 raw rx bit", v, exp_read(15));

        // R8 mask and irq
        check("R8 irq masked off", {31'd0, irq}, 32'd0);
        bus_wr(12'h038, 32'hFFFF_FF10, 1'b0); model_write(14, 32'hFFFF_FF10);
        check("R8 irq on", {31'd0, irq}, 32'd1);
        bus_rd(12'h040, v, p);
        check("R8 masked read", v, exp_read(16));

        // R9 clear and set-wins
        bus_wr(12'h044, 32'h0000_0010, 1'b1);
        m_raw[4] = 1'b1;
        bus_rd(12'h03C, v, p);
        check("R9 set wins over clear", v, exp_read(15));
        bus_wr(12'h044, 32'h0000_0010, 1'b0); model_write(17, 32'h10);
        bus_rd(12'h03C, v, p);
        check("R9 clear bit4 only", v, exp_read(15));
        check("R9 irq after clear", {31'd0, irq}, 32'd0);

        // R11 unmapped
        bus_wr(12'h00C, 32'hFFFF_FFFF, 1'b0);
        bus_wr(12'h800, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h00C, v, p);
        check("R11 unmapped read", v, 32'd0);
        for (int k = 8; k <= 18; k++) begin
            if (k == 17) continue;
            bus_rd(12'(k * 4), v, p);
            check("R11 regs unchanged", v, exp_read(k));
        end

        // R2 random register traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) begin
                idx = cfg_idx[$urandom_range(0, 8)];
                v = $urandom;
                bus_wr(12'(idx * 4), v, 1'b0); model_write(idx, v);
            end else if (op == 1) begin
                v = $urandom;
                bus_wr(12'h044, v, 1'b0); model_write(17, v);
            end else if (op == 2) begin
                bus_wr(12'h000, $urandom, 1'b0); model_write(0, 32'd0);
            end else begin
                idx = int'($urandom_range(0, 19));
                bus_rd(12'(idx * 4), v, p);
                check("R2 random read", v, exp_read(idx));
                check("R8 irq level", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            end
        end
        check("R2 ctrl pin", {16'd0, ctrl}, m_cfg[12] & 32'hFFFF);
        check("R2 line pin", {16'd0, line}, m_cfg[11] & 32'hFFFF);
        check("R2 ibaud pin", {16'd0, ibaud}, m_cfg[9] & 32'hFFFF);
        check("R2 dma pin", {16'd0, dma}, m_cfg[18] & 32'hFFFF);

        finish_run();
    end
endmodule